// File: doc/BRIEF.md
# Stack Pointer with Optional Extended Range

This block keeps the stack pointer of an 8051-style processor core. In its default mode the pointer is a plain 8-bit value that addresses the 256 bytes of on-chip RAM and wraps from FFh back to 00h. When a mode bit in a configuration register is set, three more upper bits join the pointer to form an 11-bit address. The stack can then climb past the top of on-chip RAM into the upper 1792 bytes (0100h to 07FFh) of an on-chip extended data RAM.

In extended mode, addresses below 0100h still select internal RAM. The lowest 256 bytes of extended RAM therefore never hold stack data, and the region output tells the memory system which RAM the current address selects.

The core sends single-cycle push and pop requests. A push pre-increments the pointer, so the core writes at the new address on the following cycle. A pop is issued after the core has read at the current address, and it post-decrements the pointer. The core reaches the low byte, the high bits and the mode bit through byte-wide special function register (SFR) accesses. Register writes and pointer steps take effect on the rising clock edge. Register reads are combinational.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the low byte reads 07h, the high register reads 00h, the mode bit is 0, `stk_addr_o` is 007h and `xram_sel_o` is 0.
- R2: The SFR at 81h reads and writes the full low byte. The SFR at B7h stores bits [2:0] and reads 0 in bits [7:3]. The SFR at AFh holds the mode in bit 7 and reads 0 in its other bits. Any other address reads 00h. Reads are combinational, and writes apply at the next rising edge.
- R3: In default mode (mode bit 0) a push increments the low byte modulo 256, so FFh becomes 00h. The high register does not change.
- R4: In default mode a pop decrements the low byte modulo 256, so 00h becomes FFh. The high register does not change.
- R5: In default mode `stk_addr_o` is {000b, low byte} whatever the high register holds. In extended mode it is {high[2:0], low byte}. Changing the mode bit changes the address without altering either register.
- R6: In extended mode a push increments the 11-bit pointer. 00FFh becomes 0100h, and 07FFh becomes 0000h. The carry is visible in the high register.
- R7: In extended mode a pop decrements the 11-bit pointer. 0100h becomes 00FFh, and 0000h becomes 07FFh.
- R8: `xram_sel_o` is 1 exactly when the mode bit is 1 and `stk_addr_o` is 0100h or above. Otherwise it is 0.
- R9: A push and a pop in the same cycle cancel, and the pointer does not change.
- R10: A cycle with `sfr_we_i` high drops any push or pop in that cycle. Only the register write takes effect.
- R11: With no push, pop or write, the pointer and the mode hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Pre-increment request |
| pop_i | input | 1 | Post-decrement request |
| sfr_we_i | input | 1 | SFR write strobe |
| sfr_addr_i | input | 8 | SFR address for reads and writes |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | SFR read data for `sfr_addr_i` |
| stk_addr_o | output | 11 | Effective stack address |
| xram_sel_o | output | 1 | 1 when the address selects extended RAM |

## Verification
Pushes and pops start from pointer values next to each seam: FEh/FFh/00h of the low byte, 00FFh/0100h, and 07FFh/0000h. This tells the 8-bit wrap apart from the 11-bit carry into the high bits. The same low byte is also observed with a non-zero high register under both modes. That separates "high bits ignored" from "high bits cleared", because the high register is read back after switching modes. Colliding requests (push with pop, push with a register write) check which action wins, and idle cycles confirm that nothing drifts.

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter logic [7:0] LO_ADDR  = 8'h81,
  parameter logic [7:0] HI_ADDR  = 8'hB7,
  parameter logic [7:0] CFG_ADDR = 8'hAF,
  parameter logic [7:0] RESET_LO = 8'h07,
  parameter int         HI_W     = 3,
  parameter int         MODE_BIT = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_i,
  input  logic                pop_i,
  input  logic                sfr_we_i,
  input  logic [7:0]          sfr_addr_i,
  input  logic [7:0]          sfr_wdata_i,
  output logic [7:0]          sfr_rdata_o,
  output logic [HI_W+7:0]     stk_addr_o,
  output logic                xram_sel_o
);
  localparam int AW = HI_W + 8;

  logic [7:0]      lo_q;
  logic [HI_W-1:0] hi_q;
  logic            ext_q;

  wire [AW-1:0] ptr     = {hi_q, lo_q};
  wire [AW-1:0] ptr_inc = ptr + AW'(1);
  wire [AW-1:0] ptr_dec = ptr - AW'(1);

  wire wr_lo  = sfr_we_i && (sfr_addr_i == LO_ADDR);
  wire wr_hi  = sfr_we_i && (sfr_addr_i == HI_ADDR);
  wire wr_cfg = sfr_we_i && (sfr_addr_i == CFG_ADDR);
  wire go_up  = push_i && !pop_i && !sfr_we_i;
  wire go_dn  = pop_i && !push_i && !sfr_we_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= RESET_LO;
      hi_q  <= '0;
      ext_q <= 1'b0;
    end else begin
      if (wr_lo)  lo_q  <= sfr_wdata_i;
      if (wr_hi)  hi_q  <= sfr_wdata_i[HI_W-1:0];
      if (wr_cfg) ext_q <= sfr_wdata_i[MODE_BIT];
      if (go_up) begin
        if (ext_q) {hi_q, lo_q} <= ptr_inc;
        else       lo_q <= lo_q + 8'd1;
      end
      if (go_dn) begin
        if (ext_q) {hi_q, lo_q} <= ptr_dec;
        else       lo_q <= lo_q - 8'd1;
      end
    end
  end

  assign stk_addr_o = ext_q ? ptr : {{HI_W{1'b0}}, lo_q};
  assign xram_sel_o = ext_q && (hi_q != '0);

  always_comb begin
    sfr_rdata_o = 8'h00;
    if (sfr_addr_i == LO_ADDR)  sfr_rdata_o = lo_q;
    if (sfr_addr_i == HI_ADDR)  sfr_rdata_o[HI_W-1:0] = hi_q;
    if (sfr_addr_i == CFG_ADDR) sfr_rdata_o[MODE_BIT] = ext_q;
  end

  // R8
  region_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xram_sel_o |-> (stk_addr_o[AW-1:8] != '0));

  // R3
  dflt_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_up && !ext_q) |=> (stk_addr_o[7:0] == $past(stk_addr_o[7:0]) + 8'd1) && $stable(hi_q));

  // R4
  dflt_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_dn && !ext_q) |=> (stk_addr_o[7:0] == $past(stk_addr_o[7:0]) - 8'd1) && $stable(hi_q));

  // R6
  ext_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_up && ext_q) |=> stk_addr_o == $past(stk_addr_o) + AW'(1));

  // R7
  ext_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_dn && ext_q) |=> stk_addr_o == $past(stk_addr_o) - AW'(1));

  // R9
  collide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !sfr_we_i) |=> $stable(stk_addr_o));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i && !sfr_we_i) |=> $stable(stk_addr_o) && $stable(xram_sel_o));
endmodule

// File: tb/test_stack_ptr_unit.sv
module test_stack_ptr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0, pop_i = 1'b0, sfr_we_i = 1'b0;
  logic [7:0]  sfr_addr_i = 8'h00, sfr_wdata_i = 8'h00;
  logic [7:0]  sfr_rdata_o;
  logic [10:0] stk_addr_o;
  logic        xram_sel_o;
  int total = 0, bad = 0;

  localparam logic [7:0] A_LO = 8'h81, A_HI = 8'hB7, A_CFG = 8'hAF;

  always #4 clk = ~clk;

  stack_ptr_unit i_stack_ptr_unit (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .sfr_we_i(sfr_we_i), .sfr_addr_i(sfr_addr_i), .sfr_wdata_i(sfr_wdata_i),
    .sfr_rdata_o(sfr_rdata_o), .stk_addr_o(stk_addr_o), .xram_sel_o(xram_sel_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic pu, input logic po, input logic we,
                      input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    push_i = pu; pop_i = po; sfr_we_i = we; sfr_addr_i = a; sfr_wdata_i = d;
    @(negedge clk);
    push_i = 0; pop_i = 0; sfr_we_i = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    sfr_addr_i = a;
    #1;
    v = sfr_rdata_o;
  endtask

  task automatic load(input logic ext, input logic [2:0] hi, input logic [7:0] lo);
    step(0, 0, 1, A_CFG, {ext, 7'h00});
    step(0, 0, 1, A_HI, {5'h00, hi});
    step(0, 0, 1, A_LO, lo);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 addr", stk_addr_o, 11'h007);
    chk("R1 region", xram_sel_o, 0);
    rd(A_LO, v);  chk("R1 lo", v, 8'h07);
    rd(A_HI, v);  chk("R1 hi", v, 8'h00);
    rd(A_CFG, v); chk("R1 cfg", v, 8'h00);
  endtask

  task automatic t_sfr;
    logic [7:0] v;
    step(0, 0, 1, A_LO, 8'hAA);  rd(A_LO, v);  chk("R2 lo rw", v, 8'hAA);
    step(0, 0, 1, A_HI, 8'hFF);  rd(A_HI, v);  chk("R2 hi mask", v, 8'h07);
    step(0, 0, 1, A_CFG, 8'hFF); rd(A_CFG, v); chk("R2 cfg set", v, 8'h80);
    step(0, 0, 1, A_CFG, 8'h7F); rd(A_CFG, v); chk("R2 cfg clr", v, 8'h00);
    rd(8'h90, v); chk("R2 other", v, 8'h00);
  endtask

  task automatic t_default;
    logic [7:0] v;
    load(0, 3'd5, 8'hFE);
    chk("R5 hi ignored", stk_addr_o, 11'h0FE);
    step(1, 0, 0, 0, 0); chk("R3 push", stk_addr_o, 11'h0FF);
    chk("R5 region", xram_sel_o, 0);
    step(1, 0, 0, 0, 0); chk("R3 wrap", stk_addr_o, 11'h000);
    rd(A_HI, v); chk("R3 hi kept", v, 8'h05);
    step(0, 1, 0, 0, 0); chk("R4 wrap", stk_addr_o, 11'h0FF);
    step(0, 1, 0, 0, 0); chk("R4 pop", stk_addr_o, 11'h0FE);
    rd(A_HI, v); chk("R4 hi kept", v, 8'h05);
    step(0, 0, 1, A_CFG, 8'h80);
    chk("R5 ext addr", stk_addr_o, 11'h5FE);
    chk("R8 ext region", xram_sel_o, 1);
    step(0, 0, 1, A_CFG, 8'h00);
    chk("R5 back", stk_addr_o, 11'h0FE);
    chk("R8 off region", xram_sel_o, 0);
  endtask

  task automatic t_ext_push;
    logic [7:0] v;
    load(1, 3'd0, 8'hFE);
    step(1, 0, 0, 0, 0); chk("R6 push", stk_addr_o, 11'h0FF);
    chk("R8 internal", xram_sel_o, 0);
    step(1, 0, 0, 0, 0); chk("R6 seam", stk_addr_o, 11'h100);
    chk("R8 xram", xram_sel_o, 1);
    rd(A_HI, v); chk("R6 carry", v, 8'h01);
    load(1, 3'd7, 8'hFF);
    step(1, 0, 0, 0, 0); chk("R6 top wrap", stk_addr_o, 11'h000);
    chk("R8 wrap region", xram_sel_o, 0);
  endtask

  task automatic t_ext_pop;
    logic [7:0] v;
    load(1, 3'd1, 8'h00);
    step(0, 1, 0, 0, 0); chk("R7 seam", stk_addr_o, 11'h0FF);
    chk("R8 back internal", xram_sel_o, 0);
    rd(A_HI, v); chk("R7 borrow", v, 8'h00);
    load(1, 3'd0, 8'h00);
    step(0, 1, 0, 0, 0); chk("R7 bottom wrap", stk_addr_o, 11'h7FF);
    rd(A_HI, v); chk("R7 hi", v, 8'h07);
  endtask

  task automatic t_collide;
    load(1, 3'd2, 8'h40);
    step(1, 1, 0, 0, 0); chk("R9 push+pop", stk_addr_o, 11'h240);
    step(1, 0, 1, A_LO, 8'h10); chk("R10 write wins", stk_addr_o, 11'h210);
    step(0, 1, 1, A_CFG, 8'h80); chk("R10 pop dropped", stk_addr_o, 11'h210);
  endtask

  task automatic t_idle;
    repeat (5) @(negedge clk);
    chk("R11 idle addr", stk_addr_o, 11'h210);
    chk("R11 idle region", xram_sel_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_sfr;
    t_default;
    t_ext_push;
    t_ext_pop;
    t_collide;
    t_idle;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule